// File: doc/BRIEF.md
# Reload-Match PWM Timer

This block produces one pulse-width-modulated output from a free-running up-counter. When the counter passes its all-ones value it does not wrap to zero. It reloads from a programmable load value, so the load sets the length of the period. The output goes active on each reload and returns inactive when the count equals a programmable match value, so the match value measured from the load sets the active time.

Software reaches the block through a single-cycle write port with four registers: control, live count, load and match. The count, load and match registers take new values while the timer runs, and each write acts on the live cycle at once. There is no shadow copy waiting for a period boundary. A mid-cycle update can therefore produce one cycle with mixed settings, and the length of that cycle is defined. The control register holds a run bit and an output-polarity bit. While the timer runs, the only control change it accepts is a stop.

The sequencing is a three-state machine. IDLE means stopped. RUN_LO means running with the output inactive. RUN_HI means running with the output active. The transitions are:
- start: IDLE to RUN_LO.
- rise: RUN_LO to RUN_HI, on overflow.
- reload: RUN_HI to RUN_HI, on overflow.
- fall: RUN_HI to RUN_LO, on match.
- stop: RUN_LO or RUN_HI to IDLE.

Top module: `rm_pwm_timer`

## Requirements
- R1: After reset the timer is stopped. Count, load, match and polarity are all zero, pwm_o is 0 and active_o is 0.
- R2: While running with no count write, the count rises by one on each clock. In the clock where the count is all-ones (overflow), the next count is the load value.
- R3: The output becomes active on the overflow edge. With load L and match M, where L <= M < 2^W-1, it stays active for M-L+1 clocks, and the period is 2^W-L clocks.
- R4: When overflow and a match fall in the same clock (M all-ones), overflow wins: the output stays active and does not drop.
- R5: A match write while active, to a value above the current count, ends the active time in the same cycle. The first inactive clock shows count newM+1.
- R6: A match write while active, to a value below the current count, gives no match in that cycle. The output stays active through the overflow and drops after newM in the next cycle. The active time is (2^W-L)+(newM-L+1) clocks.
- R7: A load write during a cycle changes nothing until the next overflow. That overflow reloads the new value.
- R8: Once the output has dropped, no match raises or re-drops it. It stays inactive until the next overflow, even if a count write makes the count pass the match value again.
- R9: A count write replaces the live count on the next edge and overrides both reload and match. A write issued in the clock where the count equals the match keeps the output active.
- R10: The control register is at address 0, with bit 0 = run and bit 1 = polarity. When stopped, a write loads both bits. When running, a write with bit 0 = 0 stops the timer, and every other control field is ignored. The other addresses are 1 = count, 2 = load and 3 = match.
- R11: When stopped, the count holds and pwm_o shows the polarity bit (inactive level). On start the count resumes from the held value with the output inactive until the first overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count, 2 load, 3 match |
| wr_data | input | W | Write data |
| pwm_o | output | 1 | PWM output (active level is the inverse of the polarity bit) |
| active_o | output | 1 | High while the timer runs |
| count_o | output | W | Live counter value |

## Verification
The assertions take for granted that reset is applied before the first edge. They also assume that wr_addr and wr_data are known whenever wr_en is high. No further constraint on write timing is assumed, because every mixed-setting case is defined. The bench issues writes one at a time. It drives each write half a cycle before the edge that captures it and holds wr_en low between writes, so every write lands in a known cycle relative to the count. The swept configurations keep the load at or below the match and the match below all-ones, except in the one case that deliberately tests overflow priority.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN_LO = 2'd1,
        ST_RUN_HI = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_LOAD  = 2'd2;
    localparam logic [1:0] ADDR_MATCH = 2'd3;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_POL_BIT = 1;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         is_idle,
    output logic [W-1:0] load_q,
    output logic [W-1:0] match_q,
    output logic         pol_q
);

    // Load and match are live: a write lands on the next edge, running or not.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_LOAD)  load_q  <= wr_data;
            if (wr_addr == ADDR_MATCH) match_q <= wr_data;
        end
    end

    // Polarity is a locked control field: only taken while stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pol_q <= 1'b0;
        else if (wr_en && wr_addr == ADDR_CTRL && is_idle)
            pol_q <= wr_data[CTRL_POL_BIT];
    end

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] load_q,
    output logic [W-1:0] cnt_q,
    output logic         at_top
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    assign at_top = (cnt_q == CNT_TOP);

    // Software write beats reload and increment; stopped means hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wr_data;
        else if (running) begin
            if (at_top)
                cnt_q <= load_q;
            else
                cnt_q <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/pwm_tmr_fsm.sv
module pwm_tmr_fsm
    import pwm_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       at_top,
    input  logic       at_match,
    input  logic       cnt_wr,
    input  logic       pol_q,
    output tmr_state_e state_q,
    output logic       pwm_o,
    output logic       active_o
);

    tmr_state_e state_d;
    logic       ovf_ev;
    logic       hit_ev;

    // A count write in the same clock suppresses both events.
    assign ovf_ev = at_top   && !cnt_wr;
    assign hit_ev = at_match && !cnt_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) state_d = ST_RUN_LO;          // start
            end
            ST_RUN_LO: begin
                if (stop_req)    state_d = ST_IDLE;          // stop
                else if (ovf_ev) state_d = ST_RUN_HI;        // rise
            end
            ST_RUN_HI: begin
                if (stop_req)    state_d = ST_IDLE;          // stop
                else if (ovf_ev) state_d = ST_RUN_HI;        // reload wins
                else if (hit_ev) state_d = ST_RUN_LO;        // fall
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active_o = (state_q != ST_IDLE);
        pwm_o    = pol_q ^ (state_q == ST_RUN_HI);
    end

endmodule

// File: rtl/rm_pwm_timer.sv
module rm_pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_o,
    output logic         active_o,
    output logic [W-1:0] count_o
);

    tmr_state_e   state_q;
    logic [W-1:0] load_q;
    logic [W-1:0] match_q;
    logic [W-1:0] cnt_q;
    logic         pol_q;
    logic         at_top;
    logic         at_match;
    logic         is_idle;
    logic         ctrl_wr;
    logic         cnt_wr;
    logic         start_req;
    logic         stop_req;

    assign is_idle   = (state_q == ST_IDLE);
    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);
    assign start_req = ctrl_wr &&  wr_data[CTRL_RUN_BIT];
    assign stop_req  = ctrl_wr && !wr_data[CTRL_RUN_BIT];
    assign at_match  = (cnt_q == match_q);
    assign count_o   = cnt_q;

    pwm_tmr_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .is_idle (is_idle),
        .load_q  (load_q),
        .match_q (match_q),
        .pol_q   (pol_q)
    );

    pwm_tmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (!is_idle),
        .cnt_wr  (cnt_wr),
        .wr_data (wr_data),
        .load_q  (load_q),
        .cnt_q   (cnt_q),
        .at_top  (at_top)
    );

    pwm_tmr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .at_top    (at_top),
        .at_match  (at_match),
        .cnt_wr    (cnt_wr),
        .pol_q     (pol_q),
        .state_q   (state_q),
        .pwm_o     (pwm_o),
        .active_o  (active_o)
    );

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk
    import pwm_tmr_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input tmr_state_e   state_q,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] load_q,
    input logic         pol_q,
    input logic         cnt_wr,
    input logic         stop_req,
    input logic         pwm_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !cnt_wr && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + W'(1));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !cnt_wr && cnt_q == TOP) |=> cnt_q == $past(load_q));

    p_rise_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN_HI) |-> $past(cnt_q) == TOP);

    p_top_keeps_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_HI && cnt_q == TOP && !cnt_wr && !stop_req) |=> state_q == ST_RUN_HI);

    p_low_until_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_LO && !(cnt_q == TOP && !cnt_wr)) |=> state_q != ST_RUN_HI);

    p_write_no_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_HI && cnt_wr && !stop_req) |=> state_q == ST_RUN_HI);

    p_pol_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> pol_q == $past(pol_q));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cnt_wr) |=> cnt_q == $past(cnt_q));

    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> pwm_o == pol_q);

endmodule

bind rm_pwm_timer pwm_tmr_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .load_q   (load_q),
    .pol_q    (pol_q),
    .cnt_wr   (cnt_wr),
    .stop_req (stop_req),
    .pwm_o    (pwm_o)
);

// File: tb/rm_pwm_timer_bench.sv
module rm_pwm_timer_bench;

    localparam int W    = 8;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o;
    logic         active_o;
    logic [W-1:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rm_pwm_timer #(.W(W)) u_rm_pwm_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_o    (pwm_o),
        .active_o (active_o),
        .count_o  (count_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write is captured by the next posedge.
    task automatic wr(input logic [1:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic adv_to(input int v);
        while (int'(count_o) != v) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic p;
        p = pwm_o;
        @(negedge clk);
        while (!(p == 1'b0 && pwm_o == 1'b1)) begin
            p = pwm_o;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int hi, output int per);
        wait_rise();
        hi = 0;
        while (pwm_o) begin hi++; @(negedge clk); end
        per = hi;
        while (!pwm_o) begin per++; @(negedge clk); end
    endtask

    task automatic setup(input int l, input int m);
        wr(2'd0, 0);
        wr(2'd2, l);
        wr(2'd3, m);
        wr(2'd1, SPAN - 1);
        wr(2'd0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi, per, l, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pwm_o", int'(pwm_o), 0);
        chk("R1 active_o", int'(active_o), 0);
        chk("R1 count_o", int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R1 count held after reset", int'(count_o), 0);

        // R2 counting and reload
        setup(200, 220);
        chk("R2 count at top", int'(count_o), SPAN - 1);
        chk("R2 active", int'(active_o), 1);
        @(negedge clk);
        chk("R2 reload value", int'(count_o), 200);
        chk("R3 rise on reload", int'(pwm_o), 1);
        @(negedge clk);
        chk("R2 increment", int'(count_o), 201);

        // R3 sweep of load and match
        for (int li = 0; li < 4; li++) begin
            l = SPAN - (64 >> li);
            for (int m = l; m < SPAN - 1; m++) begin
                setup(l, m);
                measure(hi, per);
                measure(hi, per);
                chk($sformatf("R3 high L=%0d M=%0d", l, m), hi, m - l + 1);
                chk($sformatf("R3 period L=%0d M=%0d", l, m), per, SPAN - l);
            end
        end

        // R4 match at all-ones: overflow wins, output never drops
        setup(200, SPAN - 1);
        wait_rise();
        n = 0;
        for (int i = 0; i < 150; i++) begin
            if (!pwm_o) n++;
            @(negedge clk);
        end
        chk("R4 inactive samples", n, 0);

        // R5 match raised above count while active
        setup(200, 250);
        wait_rise();
        adv_to(210);
        wr(2'd3, 230);
        while (pwm_o) @(negedge clk);
        chk("R5 first low count", int'(count_o), 231);

        // R6 match lowered below count while active
        setup(200, 250);
        wait_rise();
        hi = 0;
        while (int'(count_o) != 240) begin hi++; @(negedge clk); end
        wr(2'd3, 220);
        hi++;
        while (pwm_o) begin hi++; @(negedge clk); end
        chk("R6 stretched high", hi, (SPAN - 200) + (220 - 200 + 1));
        chk("R6 first low count", int'(count_o), 221);

        // R7 load written mid-cycle acts at next overflow
        setup(200, 240);
        wait_rise();
        adv_to(245);
        wr(2'd2, 230);
        chk("R7 count unchanged by load write", int'(count_o), 246);
        wait_rise();
        chk("R7 new reload value", int'(count_o), 230);
        measure(hi, per);
        chk("R7 new high", hi, 240 - 230 + 1);
        chk("R7 new period", per, SPAN - 230);

        // R8 stays low after fall although count passes match again
        setup(200, 210);
        wait_rise();
        while (pwm_o) @(negedge clk);
        wr(2'd1, 200);
        adv_to(215);
        chk("R8 low after repass", int'(pwm_o), 0);
        adv_to(SPAN - 1);
        chk("R8 low at top", int'(pwm_o), 0);
        @(negedge clk);
        chk("R8 rises at overflow", int'(pwm_o), 1);

        // R9 count write in the match clock suppresses the match
        setup(200, 230);
        wait_rise();
        adv_to(230);
        wr(2'd1, 205);
        chk("R9 still high", int'(pwm_o), 1);
        chk("R9 count written", int'(count_o), 205);
        while (pwm_o) @(negedge clk);
        chk("R9 fall after rematch", int'(count_o), 231);

        // R11 stop holds count, output inactive; restart resumes
        adv_to(240);
        wr(2'd0, 0);
        chk("R11 stopped", int'(active_o), 0);
        chk("R11 stop count", int'(count_o), 241);
        repeat (5) @(negedge clk);
        chk("R11 count held", int'(count_o), 241);
        chk("R11 idle level", int'(pwm_o), 0);
        wr(2'd0, 1);
        chk("R11 resume count", int'(count_o), 241);
        @(negedge clk);
        chk("R11 resume increments", int'(count_o), 242);
        chk("R11 low before overflow", int'(pwm_o), 0);

        // R10 control: polarity only while stopped; stop accepted while running
        wr(2'd0, 0);
        wr(2'd0, 2);
        chk("R10 polarity taken when stopped", int'(pwm_o), 1);
        wr(2'd1, 100);
        wr(2'd0, 3);
        chk("R10 started", int'(active_o), 1);
        wr(2'd0, 1);
        chk("R10 polarity write ignored while running", int'(pwm_o), 1);
        chk("R10 run write no effect", int'(active_o), 1);
        wr(2'd0, 0);
        chk("R10 stop accepted", int'(active_o), 0);
        chk("R10 polarity kept on stop", int'(pwm_o), 1);
        wr(2'd0, 0);
        chk("R10 polarity cleared when stopped", int'(pwm_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule